// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block turns the raster position of a small bitmap display into memory read addresses. It also turns the fetched bytes into pixels. The display reads its image straight out of system memory. The image is laid out in blocks of 512 bytes, and the layout changes with the display mode. Four modes exist:

- colour at 32x32
- monochrome at 64x64
- colour at 64x64
- monochrome at 128x128

The two larger modes take four blocks. The right half of each line sits one block above the left half, and the lower half of the picture sits two blocks above the upper half. A monochrome byte covers a cell 4 dots wide and 2 lines tall, with an interleaved bit order.

The raster position arrives as two counters in units of the finest grid, 128 by 128 positions. Positions beyond 127 in either direction are blanking. Software writes a block-aligned base address at any time. The new base only applies once the raster reaches vertical blanking, so the next frame starts cleanly from the new buffer. Two status outputs report whether the frame is in its active part and which line parity is being scanned. Software uses them to time buffer swaps.

Top module: `frame_scan_agen`

## Requirements
- R1: `mode_sel[1]` selects the larger resolution and `mode_sel[0]` selects monochrome. On the 128x128 grid each pixel covers the following area:
  - colour at 32x32: 4x4 positions
  - monochrome at 64x64: 2x2 positions
  - colour at 64x64: 2x2 positions
  - monochrome at 128x128: 1x1 position
- R2: In the two smaller modes the address is base×512 + row×16 + byte column, where row and byte column are counted in bytes. A colour byte spans 2 pixels across. A monochrome byte spans 4 dots across and 2 lines down. The address never leaves the 512-byte block at the base.
- R3: In the two larger modes the address is base×512 + (lower half)×1024 + (right half)×512 + (row mod 32)×16 + (byte column mod 16). Byte columns run 0..31 and rows run 0..63. All addresses are taken modulo 65536.
- R4: In colour modes the low nibble of a byte is the left pixel and the high nibble is the right pixel.
- R5: In monochrome modes the upper line of a cell uses bits 0, 1, 4, 5 from left to right. The lower line uses bits 2, 3, 6, 7.
- R6: `mem_addr` follows the counters after one clock edge. `mem_rdata` is sampled during the cycle after the address is presented. The pixel appears one edge after that, two edges after the counters.
- R7: During blanking both pixel outputs are zero. `pix_color` is zero in monochrome modes. `pix_mono` is zero in colour modes.
- R8: `frame_active` is high, one edge after the counters, exactly when `v_cnt` < 128. It falls when the raster enters the bottom blanking.
- R9: `odd_line` equals bit 0 of `v_cnt`, delayed by one edge.
- R10: A base write is held as pending. It is copied into the base in use on every edge where `v_cnt` ≥ 128. A write made during the active frame therefore does not change that frame's addresses.
- R11: While reset is asserted, all outputs are zero and both the pending and in-use base are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cnt | input | CNT_W | Horizontal raster position, 0..127 active |
| v_cnt | input | CNT_W | Vertical raster position, 0..127 active |
| mode_sel | input | 2 | Bit 1 selects the larger resolution, bit 0 selects monochrome |
| base_wr | input | 1 | Base-address write strobe |
| base_wdata | input | ADDR_W-9 | New base, address bits above bit 8 |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Byte returned for `mem_addr` |
| pix_color | output | 4 | Colour pixel value |
| pix_mono | output | 1 | Monochrome dot |
| odd_line | output | 1 | Line parity status |
| frame_active | output | 1 | High during the active frame |

## Verification
The embedded assertions check several properties on every cycle:
- Every active-region address stays inside the 512-byte or 2048-byte window above the base in use.
- The base in use never moves while the frame is active.
- Blanking yields zero pixels.
- Each pixel output stays silent in the modes that do not use it.

Only the bench scenarios can show the exact address formulas, including the quadrant split and the wrap past the top of memory. The same holds for the nibble and the interleaved bit order within each byte, which are checked by comparing every pixel of a full frame in each mode against a reference mapping. The same holds for deferring base writes, made both mid-frame and during blanking, to the following frame.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Per-pixel selection data carried alongside a fetch
  typedef struct packed {
    logic       active;   // raster inside the 128x128 window
    logic       mono;     // monochrome mode
    logic [2:0] bsel;     // colour: bit 0 picks nibble; mono: bit index
  } pix_sel_t;

  localparam int GRID_W    = 7;   // log2 of the finest grid
  localparam int BLK_SHIFT = 9;   // one block is 512 bytes
  localparam int OFS_W     = 11;  // offset spans four blocks

endpackage

// File: rtl/scan_addr_map.sv
module scan_addr_map
  import scan_pkg::*;
(
  input  logic [GRID_W-1:0] x,
  input  logic [GRID_W-1:0] y,
  input  logic              hires,
  input  logic              mono,
  output logic [OFS_W-1:0]  offset,
  output logic [2:0]        bsel
);

  // Byte offset inside the frame image
  always_comb begin
    if (hires) begin
      // byte column is x[6:2]; byte row is y[6:1]
      // quadrant bits: vertical half then horizontal half
      offset = {y[6], x[6], y[5:1], x[5:2]};
    end else begin
      // byte column is x[6:3]; byte row is y[6:2]
      offset = {2'b00, y[6:2], x[6:3]};
    end
  end

  // Selection of the bits inside the byte
  always_comb begin
    unique case ({hires, mono})
      2'b00:   bsel = {2'b00, x[2]};
      2'b01:   bsel = {x[2], y[1], x[1]};
      2'b10:   bsel = {2'b00, x[1]};
      default: bsel = {x[1], y[0], x[0]};
    endcase
  end

endmodule

// File: rtl/scan_base_reg.sv
module scan_base_reg #(
  parameter int BASE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] wr_data,
  input  logic              load_en,
  output logic [BASE_W-1:0] base_q
);

  logic [BASE_W-1:0] pend_q, pend_d, base_d;

  always_comb begin
    pend_d = pend_q;
    base_d = base_q;
    if (wr_en)   pend_d = wr_data;
    if (load_en) base_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      base_q <= '0;
    end else begin
      pend_q <= pend_d;
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/scan_pixel_sel.sv
module scan_pixel_sel
  import scan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pix_sel_t sel_in,
  input  logic [7:0] rdata,
  output logic [3:0] pix_color,
  output logic     pix_mono
);

  pix_sel_t   sel_q;
  logic [7:0] byte_q, byte_d;
  logic       cap_en;

  assign cap_en = sel_in.active;

  always_comb begin
    byte_d = byte_q;
    if (cap_en) byte_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      byte_q <= '0;
    end else begin
      sel_q  <= sel_in;
      byte_q <= byte_d;
    end
  end

  logic [3:0] nib;
  logic       dot;

  always_comb begin
    nib = sel_q.bsel[0] ? byte_q[7:4] : byte_q[3:0];
    dot = byte_q[sel_q.bsel];
    pix_color = (sel_q.active && !sel_q.mono) ? nib : 4'h0;
    pix_mono  = sel_q.active && sel_q.mono && dot;
  end

endmodule

// File: rtl/frame_scan_agen.sv
module frame_scan_agen
  import scan_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        h_cnt,
  input  logic [CNT_W-1:0]        v_cnt,
  input  logic [1:0]              mode_sel,
  input  logic                    base_wr,
  input  logic [ADDR_W-BLK_SHIFT-1:0] base_wdata,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic [7:0]              mem_rdata,
  output logic [3:0]              pix_color,
  output logic                    pix_mono,
  output logic                    odd_line,
  output logic                    frame_active
);

  localparam int BASE_W = ADDR_W - BLK_SHIFT;
  localparam logic [CNT_W-1:0]  GRID_LIM  = CNT_W'(1 << GRID_W);
  localparam logic [ADDR_W-1:0] SPAN_LO   = ADDR_W'(1 << BLK_SHIFT);
  localparam logic [ADDR_W-1:0] SPAN_HI   = ADDR_W'(1 << OFS_W);

  // Raster window decode
  logic in_rows, in_active;
  assign in_rows   = v_cnt < GRID_LIM;
  assign in_active = in_rows && (h_cnt < GRID_LIM);

  // Base register with deferred load during vertical blanking
  logic [BASE_W-1:0] base_q;
  logic              base_load;
  assign base_load = !in_rows;

  scan_base_reg #(.BASE_W(BASE_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr),
    .wr_data (base_wdata),
    .load_en (base_load),
    .base_q  (base_q)
  );

  // Mode-dependent mapping
  logic [OFS_W-1:0] ofs;
  logic [2:0]       bsel;

  scan_addr_map u_map (
    .x      (h_cnt[GRID_W-1:0]),
    .y      (v_cnt[GRID_W-1:0]),
    .hires  (mode_sel[1]),
    .mono   (mode_sel[0]),
    .offset (ofs),
    .bsel   (bsel)
  );

  // Stage 1: address and status
  logic [ADDR_W-1:0] addr_d;
  pix_sel_t          sel_d, sel_q;

  always_comb begin
    addr_d      = {base_q, {BLK_SHIFT{1'b0}}} + {{(ADDR_W-OFS_W){1'b0}}, ofs};
    sel_d.active = in_active;
    sel_d.mono   = mode_sel[0];
    sel_d.bsel   = bsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr     <= '0;
      sel_q        <= '0;
      odd_line     <= 1'b0;
      frame_active <= 1'b0;
    end else begin
      mem_addr     <= addr_d;
      sel_q        <= sel_d;
      odd_line     <= v_cnt[0];
      frame_active <= in_rows;
    end
  end

  // Stage 2: byte capture and pixel selection
  scan_pixel_sel u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_in    (sel_q),
    .rdata     (mem_rdata),
    .pix_color (pix_color),
    .pix_mono  (pix_mono)
  );

  // R2: small-mode fetches stay in the block at the base
  a_r2_block_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_active) && !$past(mode_sel[1])) |->
      ((mem_addr - {$past(base_q), {BLK_SHIFT{1'b0}}}) < SPAN_LO));

  // R3: large-mode fetches stay within four blocks of the base
  a_r3_quad_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_active) && $past(mode_sel[1])) |->
      ((mem_addr - {$past(base_q), {BLK_SHIFT{1'b0}}}) < SPAN_HI));

  // R10: base in use holds during the active frame
  a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |-> $stable(base_q));

  // R7: blanking gives zero pixels
  a_r7_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_active, 2) |-> (pix_color == 4'h0 && !pix_mono));

  // R7: each pixel output silent in the other kind of mode
  a_r7_mono_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_sel[0], 2) |-> !pix_mono);

  a_r7_color_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_sel[0], 2) |-> (pix_color == 4'h0));

endmodule

// File: tb/test_frame_scan_agen.sv
`timescale 1ns/1ps
module test_frame_scan_agen;

  localparam int H_TOT = 130;
  localparam int V_TOT = 130;

  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [7:0]  h_cnt, v_cnt;
  logic [1:0]  mode_sel;
  logic        base_wr;
  logic [6:0]  base_wdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [3:0]  pix_color;
  logic        pix_mono, odd_line, frame_active;
  logic [7:0]  seed;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit mon_en = 1'b0;

  frame_scan_agen i_frame_scan_agen (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .mode_sel(mode_sel), .base_wr(base_wr), .base_wdata(base_wdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pix_color(pix_color),
    .pix_mono(pix_mono), .odd_line(odd_line), .frame_active(frame_active)
  );

  // Model memory: contents computed from address and a pattern seed
  function automatic logic [7:0] mem_fn(logic [15:0] a, logic [7:0] s);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ s;
  endfunction

  assign mem_rdata = mem_fn(mem_addr, seed);

  typedef struct packed {
    logic [15:0] addr;
    logic        chk;
    logic        hires;
    logic        act;
    logic        odd;
  } aitem_t;

  typedef struct packed {
    logic [3:0] col;
    logic       dot;
    logic       blank;
    logic       mono;
  } pitem_t;

  aitem_t aq[$];
  pitem_t pq[$];
  logic [6:0] m_pend, m_cur;

  // Reference address mapping (R1, R2, R3)
  function automatic logic [15:0] ref_addr(logic [1:0] m, int x, int y, logic [6:0] b);
    int bc, row, ofs;
    if (!m[1]) begin
      bc  = m[0] ? (x / 2) / 4 : (x / 4) / 2;
      row = m[0] ? (y / 2) / 2 : y / 4;
      ofs = row * 16 + bc;
    end else begin
      bc  = m[0] ? x / 4 : (x / 2) / 2;
      row = y / 2;
      ofs = (row / 32) * 1024 + (bc / 16) * 512 + (row % 32) * 16 + (bc % 16);
    end
    return 16'((int'(b) * 512 + ofs) % 65536);
  endfunction

  // Reference pixel extraction (R4, R5)
  function automatic pitem_t ref_pix(logic [1:0] m, int x, int y, logic [15:0] a, logic [7:0] s);
    pitem_t p;
    logic [7:0] d;
    int px, dx, dy, idx;
    d = mem_fn(a, s);
    p = '0;
    p.mono = m[0];
    if (!m[0]) begin
      px = m[1] ? x / 2 : x / 4;
      p.col = (px % 2 == 1) ? d[7:4] : d[3:0];
    end else begin
      dx = m[1] ? x : x / 2;
      dy = m[1] ? y : y / 2;
      case (dx % 4)
        0: idx = 0;
        1: idx = 1;
        2: idx = 4;
        default: idx = 5;
      endcase
      if (dy % 2 == 1) idx = idx + 2;
      p.dot = d[idx];
    end
    return p;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: one frame of raster positions, optional base write at line wr_v
  task automatic drive_frame(logic [1:0] m, logic [7:0] s, int wr_v, logic [6:0] wr_val);
    for (int v = 0; v < V_TOT; v++) begin
      for (int h = 0; h < H_TOT; h++) begin
        aitem_t ai;
        pitem_t pi;
        logic [6:0] tmp;
        bit act;
        @(negedge clk);
        h_cnt      = 8'(h);
        v_cnt      = 8'(v);
        mode_sel   = m;
        seed       = s;
        base_wr    = (v == wr_v) && (h == 0);
        base_wdata = wr_val;
        act        = (h < 128) && (v < 128);
        ai.addr  = ref_addr(m, h, v, m_cur);
        ai.chk   = act;
        ai.hires = m[1];
        ai.act   = (v < 128);
        ai.odd   = v[0];
        aq.push_back(ai);
        if (act) pi = ref_pix(m, h, v, ai.addr, s);
        else begin
          pi = '0;
          pi.blank = 1'b1;
          pi.mono  = m[0];
        end
        pq.push_back(pi);
        // R10 model: pending write and load during blanking
        tmp = m_pend;
        if (base_wr) m_pend = wr_val;
        if (v >= 128) m_cur = tmp;
      end
    end
  endtask

  // Monitor: compare outputs shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_en && !done) begin
      if (aq.size() > 0) begin
        aitem_t e;
        e = aq.pop_front();
        if (e.chk)
          check(mem_addr == e.addr, e.hires ? "R3 R6 R10" : "R2 R6 R10", "addr",
                int'(mem_addr), int'(e.addr));
        check(frame_active == e.act, "R8", "frame_active", int'(frame_active), int'(e.act));
        check(odd_line == e.odd, "R9", "odd_line", int'(odd_line), int'(e.odd));
      end
      if (pq.size() >= 2) begin
        pitem_t p;
        p = pq.pop_front();
        if (p.blank) begin
          check(pix_color == 4'h0 && !pix_mono, "R7", "blank pixel",
                int'({pix_color, pix_mono}), 0);
        end else if (p.mono) begin
          check(pix_mono == p.dot, "R5 R1 R6", "mono dot", int'(pix_mono), int'(p.dot));
          check(pix_color == 4'h0, "R7", "colour in mono", int'(pix_color), 0);
        end else begin
          check(pix_color == p.col, "R4 R1 R6", "colour pixel", int'(pix_color), int'(p.col));
          check(!pix_mono, "R7", "mono in colour", int'(pix_mono), 0);
        end
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    rst_n      = 1'b0;
    h_cnt      = '0;
    v_cnt      = '0;
    mode_sel   = 2'b00;
    base_wr    = 1'b0;
    base_wdata = '0;
    seed       = '0;
    m_pend     = '0;
    m_cur      = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check(mem_addr == 16'h0, "R11", "reset addr", int'(mem_addr), 0);
    check(pix_color == 4'h0 && !pix_mono, "R11", "reset pixel", int'({pix_color, pix_mono}), 0);
    check(!frame_active, "R11", "reset frame_active", int'(frame_active), 0);
    check(!odd_line, "R11", "reset odd_line", int'(odd_line), 0);
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    // small colour; mid-frame write must wait (R10)
    drive_frame(2'b00, 8'h00, 60, 7'h05);
    // small mono at base 0x05; next base written early in frame
    drive_frame(2'b01, 8'h5A, 10, 7'h7F);
    // large colour at top block: address wraps; write during blanking
    drive_frame(2'b10, 8'hC3, 129, 7'h12);
    // large mono at base 0x12
    drive_frame(2'b11, 8'hA5, -1, 7'h00);
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule